// File: doc/BRIEF.md
# Branch Target and Condition Unit

This unit decides, for one control-transfer instruction of an 8-bit microcontroller, whether the transfer happens and where the program counter goes next. The decoder presents an operation code along with the address of the following instruction. It also presents every field the instruction might carry: a signed 8-bit displacement, an 11-bit in-page address and a full 16-bit address. The operands complete the set: the accumulator, the 16-bit data pointer, a tested bit, the carry flag, and two comparison or counter bytes.

One clock edge after a valid request, the unit presents its results. These are a taken flag, the next program counter, the carry value to write back, the decremented counter value and a request to clear the tested bit. When the transfer is not taken, the next program counter is simply the sequential address, so the fetch stage can always load the target. The stack traffic of subroutine calls happens elsewhere; for target computation, a call behaves like the jump of the same addressing form.

Top module: `br_unit`

## Requirements
- R1: While `rst_n` is low, and on the first edge after, every output is zero.
- R2: Results are registered and appear at the rising edge after the one that samples `in_valid` high, with `out_valid` high. After an edge with `in_valid` low, `out_valid`, `taken` and `clr_bit` are 0, while `target_pc`, `carry_out` and `dec_val` keep their values. The `op_code` encoding is: 0 none, 1 short relative, 2 in-page absolute, 3 long, 4 indexed, 5 jump if bit set, 6 jump if bit clear, 7 jump if bit set and clear it, 8 jump if carry, 9 jump if no carry, 10 jump if accumulator zero, 11 jump if accumulator nonzero, 12 compare and jump if not equal, 13 decrement and jump if nonzero. Codes 14 and 15 act as code 0.
- R3: Code 1 is always taken, with target `pc_next` plus the sign-extended `rel_off`, modulo 2^16. The reach is -128 to +127.
- R4: Code 2 is always taken, with target `{pc_next[15:11], page_addr}`.
- R5: Code 3 is always taken, with target `long_addr`.
- R6: Code 4 is always taken, with target `acc + dptr` modulo 2^16, and `acc` is zero-extended.
- R7: Codes 5 and 6 are taken when `bit_val` is 1 and 0 respectively. A taken conditional code (5 to 13) uses the relative target of R3.
- R8: Code 7 is taken when `bit_val` is 1, and then `clr_bit` is 1 in the same output cycle. With `bit_val` 0, both are 0. No other code raises `clr_bit`.
- R9: Codes 8 and 9 are taken when `carry_in` is 1 and 0 respectively.
- R10: Codes 10 and 11 are taken when `acc` is zero and nonzero respectively.
- R11: Code 12 is taken when `opnd_a` differs from `opnd_b`. Its `carry_out` is 1 exactly when `opnd_a < opnd_b` (unsigned). Every other valid code passes `carry_in` to `carry_out`.
- R12: Code 13 outputs `dec_val = opnd_a - 1` modulo 256 and is taken when that value is nonzero, so 00h gives FFh and is taken. Every other valid code outputs `dec_val = opnd_a`.
- R13: A valid request that is not taken outputs `target_pc = pc_next`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op_code | input | 4 | Transfer kind, encoding in R2 |
| pc_next | input | 16 | Address following the instruction |
| rel_off | input | 8 | Signed displacement |
| page_addr | input | 11 | In-page absolute address |
| long_addr | input | 16 | Full absolute address |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| bit_val | input | 1 | Value of the tested bit |
| carry_in | input | 1 | Current carry flag |
| opnd_a | input | 8 | Compare destination or counter byte |
| opnd_b | input | 8 | Compare source byte |
| out_valid | output | 1 | Result present |
| taken | output | 1 | Transfer taken |
| target_pc | output | 16 | Next program counter |
| carry_out | output | 1 | Carry to write back |
| dec_val | output | 8 | Counter value to write back |
| clr_bit | output | 1 | Clear the tested bit |

## Verification
Two actions can coincide in one output cycle. The branch decision can come together with a write-back side effect: a bit-test-and-clear raises `taken` and `clr_bit` together, and a compare raises `taken` while it rewrites `carry_out`. Directed vectors set the tested bit both ways and the compare operands below, equal to and above one another. The behavioural model predicts all six outputs in that same cycle, so a clear issued without the jump, or a carry taken from the wrong comparison, shows as a mismatch. The wrap corners are also driven: relative displacement across address 0, the page boundary, the indexed sum past FFFFh, and the counter at 00h and 01h.

// File: rtl/br_pkg.sv
package br_pkg;
    typedef enum logic [3:0] {
        BR_NONE    = 4'd0,
        BR_SREL    = 4'd1,
        BR_PAGE    = 4'd2,
        BR_LONG    = 4'd3,
        BR_IDX     = 4'd4,
        BR_BSET    = 4'd5,
        BR_BCLR    = 4'd6,
        BR_BSETCLR = 4'd7,
        BR_CSET    = 4'd8,
        BR_CCLR    = 4'd9,
        BR_AZ      = 4'd10,
        BR_ANZ     = 4'd11,
        BR_CMPNE   = 4'd12,
        BR_DECNZ   = 4'd13
    } br_op_e;

    localparam int unsigned BR_OP_W = 4;
endpackage

// File: rtl/br_target_gen.sv
module br_target_gen
    import br_pkg::*;
#(
    parameter int unsigned PC_W   = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PAGE_W = 11
) (
    input  logic [PC_W-1:0]   pc_next,
    input  logic [DATA_W-1:0] rel_off,
    input  logic [PAGE_W-1:0] page_addr,
    input  logic [PC_W-1:0]   long_addr,
    input  logic [DATA_W-1:0] acc,
    input  logic [PC_W-1:0]   dptr,
    output logic [PC_W-1:0]   rel_tgt,
    output logic [PC_W-1:0]   page_tgt,
    output logic [PC_W-1:0]   long_tgt,
    output logic [PC_W-1:0]   idx_tgt
);
    localparam int unsigned EXT_W = PC_W - DATA_W;

    logic [PC_W-1:0] rel_sext;
    logic [PC_W-1:0] acc_zext;

    always_comb begin
        rel_sext = {{EXT_W{rel_off[DATA_W-1]}}, rel_off};
        acc_zext = {{EXT_W{1'b0}}, acc};
        rel_tgt  = pc_next + rel_sext;
        idx_tgt  = dptr + acc_zext;
        long_tgt = long_addr;
    end

    // The page field replaces the low bits; the upper bits follow the next PC.
    generate
        if (PAGE_W >= PC_W) begin : g_full_page
            always_comb page_tgt = page_addr[PC_W-1:0];
        end else begin : g_split_page
            always_comb page_tgt = {pc_next[PC_W-1:PAGE_W], page_addr};
        end
    endgenerate
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
    import br_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  br_op_e            op,
    input  logic              bit_val,
    input  logic              carry_in,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              cond_true,
    output logic              use_rel,
    output logic              cy_new,
    output logic [DATA_W-1:0] dec_res,
    output logic              clr_req
);
    logic [DATA_W-1:0] dec_tmp;
    logic              acc_zero;
    logic              a_lt_b;
    logic              a_ne_b;

    always_comb begin
        dec_tmp  = opnd_a - {{(DATA_W-1){1'b0}}, 1'b1};
        acc_zero = (acc == '0);
        a_lt_b   = (opnd_a < opnd_b);
        a_ne_b   = (opnd_a != opnd_b);

        cond_true = 1'b0;
        use_rel   = 1'b1;
        clr_req   = 1'b0;
        cy_new    = carry_in;
        dec_res   = opnd_a;

        case (op)
            BR_SREL:    cond_true = 1'b1;
            BR_PAGE:    begin cond_true = 1'b1; use_rel = 1'b0; end
            BR_LONG:    begin cond_true = 1'b1; use_rel = 1'b0; end
            BR_IDX:     begin cond_true = 1'b1; use_rel = 1'b0; end
            BR_BSET:    cond_true = bit_val;
            BR_BCLR:    cond_true = ~bit_val;
            BR_BSETCLR: begin
                cond_true = bit_val;
                clr_req   = bit_val;
            end
            BR_CSET:    cond_true = carry_in;
            BR_CCLR:    cond_true = ~carry_in;
            BR_AZ:      cond_true = acc_zero;
            BR_ANZ:     cond_true = ~acc_zero;
            BR_CMPNE:   begin
                cond_true = a_ne_b;
                cy_new    = a_lt_b;
            end
            BR_DECNZ:   begin
                dec_res   = dec_tmp;
                cond_true = (dec_tmp != '0);
            end
            default:    begin
                cond_true = 1'b0;
                use_rel   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/br_unit.sv
module br_unit
    import br_pkg::*;
#(
    parameter int unsigned PC_W   = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PAGE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op_code,
    input  logic [PC_W-1:0]   pc_next,
    input  logic [DATA_W-1:0] rel_off,
    input  logic [PAGE_W-1:0] page_addr,
    input  logic [PC_W-1:0]   long_addr,
    input  logic [DATA_W-1:0] acc,
    input  logic [PC_W-1:0]   dptr,
    input  logic              bit_val,
    input  logic              carry_in,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              out_valid,
    output logic              taken,
    output logic [PC_W-1:0]   target_pc,
    output logic              carry_out,
    output logic [DATA_W-1:0] dec_val,
    output logic              clr_bit
);
    typedef struct packed {
        logic              vld;
        logic              tkn;
        logic [PC_W-1:0]   tgt;
        logic              cy;
        logic [DATA_W-1:0] dec;
        logic              clr;
    } br_state_t;

    br_state_t st_d, st_q;

    br_op_e          op;
    logic [PC_W-1:0] rel_tgt, page_tgt, long_tgt, idx_tgt, sel_tgt;
    logic            cond_true, use_rel, cy_new, clr_req;
    logic [DATA_W-1:0] dec_res;

    assign op = br_op_e'(op_code);

    br_target_gen #(.PC_W(PC_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_tgt (
        .pc_next   (pc_next),
        .rel_off   (rel_off),
        .page_addr (page_addr),
        .long_addr (long_addr),
        .acc       (acc),
        .dptr      (dptr),
        .rel_tgt   (rel_tgt),
        .page_tgt  (page_tgt),
        .long_tgt  (long_tgt),
        .idx_tgt   (idx_tgt)
    );

    br_cond_eval #(.DATA_W(DATA_W)) u_cond (
        .op        (op),
        .bit_val   (bit_val),
        .carry_in  (carry_in),
        .acc       (acc),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .cond_true (cond_true),
        .use_rel   (use_rel),
        .cy_new    (cy_new),
        .dec_res   (dec_res),
        .clr_req   (clr_req)
    );

    always_comb begin
        if (use_rel) begin
            sel_tgt = rel_tgt;
        end else begin
            case (op)
                BR_PAGE: sel_tgt = page_tgt;
                BR_LONG: sel_tgt = long_tgt;
                BR_IDX:  sel_tgt = idx_tgt;
                default: sel_tgt = pc_next;
            endcase
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.tkn = 1'b0;
        st_d.clr = 1'b0;
        if (in_valid) begin
            st_d.tkn = cond_true;
            st_d.clr = clr_req;
            st_d.cy  = cy_new;
            st_d.dec = dec_res;
            st_d.tgt = cond_true ? sel_tgt : pc_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign taken     = st_q.tkn;
    assign target_pc = st_q.tgt;
    assign carry_out = st_q.cy;
    assign dec_val   = st_q.dec;
    assign clr_bit   = st_q.clr;
endmodule

// File: rtl/br_unit_chk.sv
module br_unit_chk
    import br_pkg::*;
#(
    parameter int unsigned PC_W   = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PAGE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        op_code,
    input logic [PC_W-1:0]   pc_next,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic              out_valid,
    input logic              taken,
    input logic [PC_W-1:0]   target_pc,
    input logic              carry_out,
    input logic [DATA_W-1:0] dec_val,
    input logic              clr_bit
);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !taken && !clr_bit));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> ($stable(target_pc) && $stable(dec_val) && $stable(carry_out)));

    p_page_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == BR_PAGE) |=>
            (taken && target_pc[PC_W-1:PAGE_W] == $past(pc_next[PC_W-1:PAGE_W])));

    p_clr_with_jump_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_bit |-> (taken && out_valid));

    p_cmp_carry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == BR_CMPNE) |=>
            (carry_out == ($past(opnd_a) < $past(opnd_b))));

    p_dec_taken_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == BR_DECNZ) |=> (taken == (dec_val != '0)));

    p_not_taken_seq_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !taken && $past(rst_n)) |-> (target_pc == $past(pc_next)));
endmodule

bind br_unit br_unit_chk #(.PC_W(PC_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_chk (.*);

// File: tb/sim_br_unit.sv
`timescale 1ns/1ps
module sim_br_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [15:0] pc_next = '0;
    logic [7:0]  rel_off = '0;
    logic [10:0] page_addr = '0;
    logic [15:0] long_addr = '0;
    logic [7:0]  acc = '0;
    logic [15:0] dptr = '0;
    logic        bit_val = 1'b0;
    logic        carry_in = 1'b0;
    logic [7:0]  opnd_a = '0;
    logic [7:0]  opnd_b = '0;
    logic        out_valid, taken, carry_out, clr_bit;
    logic [15:0] target_pc;
    logic [7:0]  dec_val;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int e_vld = 0, e_tkn = 0, e_tgt = 0, e_cy = 0, e_dec = 0, e_clr = 0;

    always #5 clk = ~clk;

    br_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .pc_next(pc_next), .rel_off(rel_off), .page_addr(page_addr),
        .long_addr(long_addr), .acc(acc), .dptr(dptr), .bit_val(bit_val),
        .carry_in(carry_in), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .out_valid(out_valid), .taken(taken), .target_pc(target_pc),
        .carry_out(carry_out), .dec_val(dec_val), .clr_bit(clr_bit)
    );

    function automatic string tag_of(int op);
        case (op)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5, 6: return "R7";
            7: return "R8";
            8, 9: return "R9";
            10, 11: return "R10";
            12: return "R11";
            13: return "R12";
            default: return "R13";
        endcase
    endfunction

    // Behavioural model of the next outputs from the inputs now applied.
    task automatic model();
        int op, pc, r, rt, tk, tgt, cy, dec, clr;
        op  = int'(op_code);
        pc  = int'(pc_next);
        r   = (int'(rel_off) >= 128) ? int'(rel_off) - 256 : int'(rel_off);
        rt  = (pc + r + 65536) % 65536;
        tk  = 0; tgt = pc; cy = int'(carry_in); dec = int'(opnd_a); clr = 0;
        case (op)
            1: begin tk = 1; tgt = rt; end
            2: begin tk = 1; tgt = (pc / 2048) * 2048 + int'(page_addr); end
            3: begin tk = 1; tgt = int'(long_addr); end
            4: begin tk = 1; tgt = (int'(acc) + int'(dptr)) % 65536; end
            5: tk = int'(bit_val);
            6: tk = 1 - int'(bit_val);
            7: begin tk = int'(bit_val); clr = int'(bit_val); end
            8: tk = int'(carry_in);
            9: tk = 1 - int'(carry_in);
            10: tk = (acc == 0) ? 1 : 0;
            11: tk = (acc != 0) ? 1 : 0;
            12: begin
                tk = (opnd_a != opnd_b) ? 1 : 0;
                cy = (int'(opnd_a) < int'(opnd_b)) ? 1 : 0;
            end
            13: begin
                dec = (int'(opnd_a) + 255) % 256;
                tk  = (dec != 0) ? 1 : 0;
            end
            default: tk = 0;
        endcase
        if (op >= 5 && op <= 13 && tk == 1) tgt = rt;
        e_vld = int'(in_valid);
        if (in_valid) begin
            e_tkn = tk; e_tgt = tgt; e_cy = cy; e_dec = dec; e_clr = clr;
        end else begin
            e_tkn = 0; e_clr = 0;
        end
    endtask

    task automatic compare(string tag);
        n_tests++;
        if (int'(out_valid) != e_vld || int'(taken) != e_tkn ||
            int'(target_pc) != e_tgt || int'(carry_out) != e_cy ||
            int'(dec_val) != e_dec || int'(clr_bit) != e_clr) begin
            n_fail++;
            $display("FAIL %s: got vld=%0d tkn=%0d tgt=%h cy=%0d dec=%h clr=%0d, expected vld=%0d tkn=%0d tgt=%h cy=%0d dec=%h clr=%0d",
                     tag, out_valid, taken, target_pc, carry_out, dec_val, clr_bit,
                     e_vld, e_tkn, e_tgt[15:0], e_cy, e_dec[7:0], e_clr);
        end
    endtask

    // Inputs are set at a falling edge; the result is checked one falling edge later.
    task automatic run(string tag);
        model();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic req(int op, int pc, string tag);
        in_valid = 1'b1;
        op_code  = 4'(op);
        pc_next  = 16'(pc);
        run(tag);
    endtask

    task automatic idle(string tag);
        in_valid = 1'b0;
        op_code  = 4'($urandom_range(0, 15));
        pc_next  = 16'($urandom);
        opnd_a   = 8'($urandom);
        carry_in = 1'($urandom);
        run(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            compare("R1");
        end
        rst_n = 1'b1;

        // R3: short relative, both directions and wrap
        rel_off = 8'h80; req(1, 16'h0010, "R3");
        rel_off = 8'h7F; req(1, 16'hFFF0, "R3");
        rel_off = 8'h00; req(1, 16'h1234, "R3");
        // R4: in-page absolute at page edges
        page_addr = 11'h7FF; req(2, 16'h0800, "R4");
        page_addr = 11'h000; req(2, 16'hFFFF, "R4");
        // R5: long
        long_addr = 16'hBEEF; req(3, 16'h0003, "R5");
        // R6: indexed with wrap
        acc = 8'hFF; dptr = 16'hFFFF; req(4, 16'h0100, "R6");
        acc = 8'h10; dptr = 16'h2400; req(4, 16'h0100, "R6");
        // R2: idle cycle holds target, quiets flags
        idle("R2");
        idle("R2");
        // R7: bit set / clear both ways
        rel_off = 8'hF0;
        bit_val = 1'b1; req(5, 16'h0200, "R7");
        bit_val = 1'b0; req(5, 16'h0200, "R7");
        bit_val = 1'b0; req(6, 16'h0300, "R7");
        bit_val = 1'b1; req(6, 16'h0300, "R7");
        // R8: test-and-clear
        bit_val = 1'b1; req(7, 16'h0400, "R8");
        bit_val = 1'b0; req(7, 16'h0400, "R8");
        // R9: carry conditions
        carry_in = 1'b1; req(8, 16'h0500, "R9");
        carry_in = 1'b0; req(8, 16'h0500, "R9");
        carry_in = 1'b0; req(9, 16'h0600, "R9");
        carry_in = 1'b1; req(9, 16'h0600, "R9");
        // R10: accumulator zero tests
        acc = 8'h00; req(10, 16'h0700, "R10");
        acc = 8'h01; req(10, 16'h0700, "R10");
        acc = 8'h00; req(11, 16'h0700, "R10");
        acc = 8'h80; req(11, 16'h0700, "R10");
        // R11: compare, carry from unsigned less-than
        carry_in = 1'b1; opnd_a = 8'h42; opnd_b = 8'h42; req(12, 16'h0800, "R11");
        carry_in = 1'b0; opnd_a = 8'h10; opnd_b = 8'hF0; req(12, 16'h0800, "R11");
        carry_in = 1'b1; opnd_a = 8'hF0; opnd_b = 8'h10; req(12, 16'h0800, "R11");
        carry_in = 1'b1; opnd_a = 8'h33; req(1, 16'h0800, "R11");
        // R12: decrement and jump
        opnd_a = 8'h01; req(13, 16'h0900, "R12");
        opnd_a = 8'h00; req(13, 16'h0900, "R12");
        opnd_a = 8'h05; req(13, 16'h0900, "R12");
        // R13: unused codes not taken
        req(14, 16'hABCD, "R13");
        req(15, 16'h1357, "R13");
        req(0,  16'h2468, "R13");

        // Mixed sequence
        for (int i = 0; i < 400; i++) begin
            rel_off   = 8'($urandom);
            page_addr = 11'($urandom);
            long_addr = 16'($urandom);
            acc       = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
            dptr      = 16'($urandom);
            bit_val   = 1'($urandom);
            carry_in  = 1'($urandom);
            opnd_a    = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
            opnd_b    = ($urandom_range(0, 3) == 0) ? opnd_a : 8'($urandom);
            if ($urandom_range(0, 4) == 0) begin
                idle("R2");
            end else begin
                int op;
                op = int'($urandom_range(0, 15));
                req(op, int'($urandom_range(0, 65535)), tag_of(op));
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule